// File: doc/BRIEF.md
# Multi-lane phase accumulator with serial MSB output

This block is a numerically controlled oscillator whose one-bit output runs at several times its core clock rate. On every slow clock edge it works out a group of consecutive phase values in parallel. The group starts at a running base and steps by the tuning word, so it holds `base + k*tune` for k = 0 .. LANES-1. The base then moves forward by `LANES*tune`. The top bit of each lane goes into a LANES-bit slice.

A shift register in the fast clock domain takes in one slice every LANES fast cycles and sends it out least-significant lane first. This emulates a single-step accumulator clocked at the fast rate. No adder has to close timing at that rate.

The fast clock runs at exactly LANES times the slow clock, and each slow rising edge falls on a fast rising edge. Reset is asynchronous and active low. It must be released so that the first fast rising edge after release is also a slow rising edge. The tuning word is sampled only on slow edges. The phase carries on across a change of tuning word.

Top module: `burst_nco`

## Requirements
- R1: While `rst_n` is low, `dout` is 0. After release, `dout` stays 0 for the first LANES+1 fast cycles, counting fast edges from 0 at the first fast edge after release. During those cycles the all-zero start-up slice is shifted out.
- R2: With a constant tuning word T, from fast edge LANES+1 onward, the value of `dout` after fast edge LANES+1+i equals bit 31 of (i*T mod 2^32), for every i >= 0.
- R3: A tuning word is captured on a slow edge. It first governs the slice loaded one slow cycle after the one that capture produces. The stepping then continues from the phase already reached, so the phase stays continuous.
- R4: Within each slice, the earliest phase leaves first. Lane 0 (the base) is shifted out in the fast cycle right after the load, then lane 1, and so on. Internally, lane k sits at bit k of the slice and `dout` is bit 0 of the shift register.
- R5: All lane sums and the base advance wrap modulo 2^32. Tuning words with bit 31 set, including 32'hFFFF_FFFF, follow R2 with no special handling.
- R6: The shift register loads a new slice exactly once every LANES fast cycles. The load happens on the fast edge one cycle after each slow edge, so the slice is never read in the same instant it changes. Between loads it shifts one lane per fast cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Core clock; lane sums and base advance |
| clk_fast | input | 1 | Serial clock at LANES times the core clock, edge aligned |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tune | input | 32 | Phase increment per fast-rate step |
| dout | output | 1 | Serial top-bit stream |

## Verification
The bench builds the block with LANES = 4 and a 32-bit accumulator. This keeps every lane and every load position visible within a few fast cycles, so every output bit over about two thousand fast cycles is compared with an arithmetic single-step reference. The tuning word changes every twenty slow cycles. The sequence covers zero, exact powers of two, words with the top bit set, all ones and pseudo-random words, so wraparound and phase continuity across changes are both exercised. Overriding the bench parameter to 8 runs the same comparison on the wider variant.

// File: rtl/burst_nco.sv
module burst_nco #(
  parameter int ACC_W = 32,
  parameter int LANES = 4
) (
  input  logic             clk_slow,
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] tune,
  output logic             dout
);
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [CW-1:0] LOAD_AT = CW'(1);

  logic [ACC_W-1:0] mult [1:LANES];
  logic [ACC_W-1:0] base;
  logic [LANES-1:0] lane_msb;
  logic [LANES-1:0] slice;
  logic [LANES-1:0] sr;
  logic [CW-1:0]    cnt;
  logic             load;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= LANES; k++) mult[k] <= '0;
    end else begin
      for (int k = 1; k <= LANES; k++) mult[k] <= tune * ACC_W'(k);
    end
  end

  assign lane_msb[0] = base[ACC_W-1];
  for (genvar k = 1; k < LANES; k++) begin : g_lane
    logic [ACC_W-1:0] sum;
    assign sum         = base + mult[k];
    assign lane_msb[k] = sum[ACC_W-1];
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      slice <= '0;
    end else begin
      base  <= base + mult[LANES];
      slice <= lane_msb;
    end
  end

  assign load = (cnt == LOAD_AT);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sr  <= '0;
    end else begin
      cnt <= (cnt == CW'(LANES - 1)) ? '0 : cnt + CW'(1);
      sr  <= load ? slice : (sr >> 1);
    end
  end

  assign dout = sr[0];
endmodule

module burst_nco_chk #(
  parameter int ACC_W = 32,
  parameter int LANES = 4
) (
  input logic             clk_slow,
  input logic             clk_fast,
  input logic             rst_n,
  input logic [ACC_W-1:0] tune,
  input logic [ACC_W-1:0] mult_one,
  input logic [LANES-1:0] slice,
  input logic [LANES-1:0] sr,
  input logic             load,
  input logic             dout
);
  logic [7:0] gap;
  logic       seen;
  logic       slow_arm;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (load) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 8'd1;
    end
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) slow_arm <= 1'b0;
    else        slow_arm <= 1'b1;
  end

  always @(negedge clk_fast) begin
    if (!rst_n) a_r1_reset_quiet: assert (dout == 1'b0);
  end

  a_r6_load_spacing: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (load && seen) |-> (gap == 8'(LANES - 1)));

  a_r4_first_lane: assert property (@(posedge clk_fast) disable iff (!rst_n)
    load |=> (dout == $past(slice[0])));

  a_r2_shift_step: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (!load) |=> (dout == $past(sr[1])));

  a_r3_tune_capture: assert property (@(posedge clk_slow) disable iff (!rst_n)
    slow_arm |-> (mult_one == $past(tune)));
endmodule

bind burst_nco burst_nco_chk #(.ACC_W(ACC_W), .LANES(LANES)) u_chk (
  .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n), .tune(tune),
  .mult_one(mult[1]), .slice(slice), .sr(sr), .load(load), .dout(dout)
);

// File: tb/burst_nco_tb.sv
module burst_nco_tb;
  parameter int LANES = 4;
  localparam int SEG   = 20;
  localparam int NSEG  = 24;
  localparam int TOTAL = SEG * NSEG;

  logic        clk_fast, clk_slow, rst_n;
  logic [31:0] tune;
  logic        dout;

  int unsigned edges, ph;
  int          n_chk, n_fail;
  bit          running, done, summarized;

  burst_nco #(.ACC_W(32), .LANES(LANES)) u_dut (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
    .tune(tune), .dout(dout)
  );

  initial begin
    clk_fast = 0; clk_slow = 0; ph = 0; edges = 0;
    forever begin
      #2;
      clk_fast = 1;
      if (ph == 0) clk_slow = 1;
      else if (ph == LANES / 2) clk_slow = 0;
      ph = (ph + 1) % LANES;
      if (rst_n) edges++;
      #2 clk_fast = 0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: dout=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input int seg, input logic [31:0] lcg);
    case (seg % 8)
      0: pick = 32'h4000_0000;
      1: pick = 32'h0000_0000;
      2: pick = 32'h8000_0000;
      3: pick = 32'hFFFF_FFFF;
      4: pick = 32'h1234_5678;
      5: pick = 32'hC000_0001;
      6: pick = 32'h2000_0000;
      default: pick = lcg;
    endcase
  endfunction

  logic [31:0] tprev, tcur, last_t, acc, lcg;
  logic [LANES-1:0] exp_bits;
  bit   have_t, chg;
  string tag;

  always @(negedge clk_fast) begin
    if (running && edges > 0 && !done) begin
      automatic int unsigned e = edges - 1;
      automatic int unsigned s = e / LANES;
      automatic logic expv;
      if (e % LANES == 0) begin
        tprev = tcur;
        tcur  = tune;
        if (s > 0 && s % SEG == 0) begin
          lcg  = lcg * 32'd1664525 + 32'd1013904223;
          tune = pick(s / SEG, lcg);
        end
        if (s >= TOTAL) done = 1;
      end
      if (e >= LANES + 1 && (e - 1) % LANES == 0) begin
        for (int k = 0; k < LANES; k++) begin
          automatic logic [31:0] pk = acc + 32'(k) * tprev;
          exp_bits[k] = pk[31];
        end
        acc = acc + 32'(LANES) * tprev;
        chg = have_t && (tprev != last_t);
        last_t = tprev;
        have_t = 1;
        if (chg) tag = "R3 phase-continuous retune";
        else if (tprev[31]) tag = "R5 wrapping word";
        else tag = "R2/R4 lane order vs single-step reference";
      end
      if (e < LANES + 1) begin
        expv = 1'b0;
        check("R1 start-up zeros", dout, expv);
      end else begin
        expv = exp_bits[(e - 1) % LANES];
        check(tag, dout, expv);
      end
    end
  end

  task automatic finish_run();
    if (!summarized) begin
      summarized = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; running = 0; done = 0; summarized = 0;
    acc = '0; tcur = '0; tprev = '0; last_t = '0; have_t = 0;
    lcg = 32'h1357_9BDF; exp_bits = '0; tag = "R2";
    rst_n = 0;
    tune  = 32'h4000_0000;
    repeat (3) begin
      @(negedge clk_fast);
      check("R1 reset holds output low", dout, 1'b0);
    end
    do @(negedge clk_fast); while (ph != 0);
    rst_n   = 1;
    running = 1;
    wait (done);
    finish_run();
  end

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end
endmodule